// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the architectural state update that a 32-bit soft processor needs when it takes an exception. When the request strobe is high, it reads a 3-bit cause code and the current program counter. It also reads the present interrupt-enable bits, a remap control bit and two vector bases, one normal and one debug. On the next clock edge it presents the handler address as the new program counter, the updated interrupt-enable bits, and the return address, which it stores in one of two link registers.

Causes fall into two groups. Breakpoint and watchpoint are debug causes. They save the return address into the breakpoint-return register, and they record the prior global enable in the debug-saved enable bit. The five other handled causes are instruction bus error, data bus error, divide by zero, external interrupt and system call. They save into the exception-return register and record the prior global enable in the exception-saved enable bit. The handler address is the chosen base plus 32 bytes per cause code. The remap bit alone picks the base, and it applies to both groups.

Cause code 0 (reset) is not handled here. It raises the error output and changes nothing else. A small state machine records the kind of the previous cycle's request. Its states are ST_IDLE, ST_NORMAL, ST_DEBUG and ST_FAULT. Any cycle with a request moves it to the state that matches the cause group. Any cycle without a request returns it to ST_IDLE. The error output is high exactly while the machine is in ST_FAULT.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, pc_o, ie_o, ea_o and ba_o become zero at the next edge, and err_o is low.
- R2: A request with a non-debug cause (codes 2, 4, 5, 6, 7) loads ea_o with pc_i and leaves ba_o unchanged.
- R3: A request with a debug cause (code 1 breakpoint, code 3 watchpoint) loads ba_o with pc_i and leaves ea_o unchanged.
- R4: On a non-debug cause, ie_o bit 1 (exception-saved enable) becomes ie_i bit 1 OR ie_i bit 0, and ie_o bit 2 becomes ie_i bit 2.
- R5: On a debug cause, ie_o bit 2 (debug-saved enable) becomes ie_i bit 2 OR ie_i bit 0, and ie_o bit 1 becomes ie_i bit 1.
- R6: On every handled cause, ie_o bit 0 (global enable) becomes 0.
- R7: On every handled cause, pc_o becomes the selected base plus cause times 32, modulo 2^32.
- R8: When remap_i is 1, the debug base dbase_i is used for all causes. When remap_i is 0, the normal base nbase_i is used for all causes.
- R9: A request with cause 0 sets err_o to 1 for the following cycle and leaves pc_o, ie_o, ea_o and ba_o unchanged.
- R10: In a cycle without a request, pc_o, ie_o, ea_o and ba_o hold their values, and err_o is 0 in the following cycle.
- R11: Every update from a request appears at the first clock edge after the cycle in which req_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Exception request strobe |
| cause_i | input | 3 | Exception cause code |
| pc_i | input | 32 | Program counter of the excepting instruction |
| ie_i | input | 3 | Current interrupt-enable bits {debug-saved, exception-saved, global} |
| remap_i | input | 1 | Selects the debug vector base |
| nbase_i | input | 32 | Normal vector base |
| dbase_i | input | 32 | Debug vector base |
| pc_o | output | 32 | Handler address |
| ie_o | output | 3 | Updated interrupt-enable bits |
| ea_o | output | 32 | Exception-return register |
| ba_o | output | 32 | Breakpoint-return register |
| err_o | output | 1 | Unhandled cause seen in the previous cycle |

## Verification
The properties assume two things about the inputs. First, req_i and cause_i carry known values at every sampled edge, so the class decode is never X. Second, the inputs the properties look back at with $past stay steady through the edge. The bench changes every input on the falling clock edge only and draws each value from a fully defined random word or from a directed constant. Random cause codes cover all eight values, so the reset code also lands in the unhandled path, and about half of all cycles carry no request.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Cause encodings; the vector offset depends on these values.
    typedef enum logic [2:0] {
        CAUSE_RESET = 3'd0,
        CAUSE_BRKPT = 3'd1,
        CAUSE_IBUS  = 3'd2,
        CAUSE_WATCH = 3'd3,
        CAUSE_DBUS  = 3'd4,
        CAUSE_DIV0  = 3'd5,
        CAUSE_IRQ   = 3'd6,
        CAUSE_SCALL = 3'd7
    } exc_cause_e;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_NORMAL = 2'd1,
        CLS_DEBUG  = 2'd2
    } exc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_DEBUG  = 2'd2,
        ST_FAULT  = 2'd3
    } exc_state_e;

    localparam int CAUSE_W = 3;
    localparam int IE_W    = 3;
    localparam int IE_GLB  = 0;
    localparam int IE_SEXC = 1;
    localparam int IE_SDBG = 2;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause_i,
    output exc_class_e         cls_o
);

    always_comb begin
        unique case (exc_cause_e'(cause_i))
            CAUSE_BRKPT,
            CAUSE_WATCH: cls_o = CLS_DEBUG;
            CAUSE_IBUS,
            CAUSE_DBUS,
            CAUSE_DIV0,
            CAUSE_IRQ,
            CAUSE_SCALL: cls_o = CLS_NORMAL;
            default:     cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc #(
    parameter int ADDR_W    = 32,
    parameter int CAUSE_W   = 3,
    parameter int VEC_SHIFT = 5
) (
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               remap_i,
    input  logic [ADDR_W-1:0]  nbase_i,
    input  logic [ADDR_W-1:0]  dbase_i,
    output logic [ADDR_W-1:0]  vec_o
);

    localparam int PAD_W = ADDR_W - CAUSE_W - VEC_SHIFT;

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] offset;

    generate
        if (VEC_SHIFT > 0) begin : g_shifted
            assign offset = {{PAD_W{1'b0}}, cause_i, {VEC_SHIFT{1'b0}}};
        end else begin : g_flat
            assign offset = {{PAD_W{1'b0}}, cause_i};
        end
    endgenerate

    assign base_sel = remap_i ? dbase_i : nbase_i;
    assign vec_o    = base_sel + offset;

endmodule

// File: rtl/exc_ie_update.sv
module exc_ie_update
    import exc_pkg::*;
(
    input  logic [IE_W-1:0] ie_i,
    input  exc_class_e      cls_i,
    output logic [IE_W-1:0] ie_o
);

    always_comb begin
        ie_o = ie_i;
        unique case (cls_i)
            CLS_NORMAL: begin
                ie_o[IE_SEXC] = ie_i[IE_SEXC] | ie_i[IE_GLB];
                ie_o[IE_GLB]  = 1'b0;
            end
            CLS_DEBUG: begin
                ie_o[IE_SDBG] = ie_i[IE_SDBG] | ie_i[IE_GLB];
                ie_o[IE_GLB]  = 1'b0;
            end
            default: ie_o = ie_i;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VEC_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [2:0]        cause_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [2:0]        ie_i,
    input  logic              remap_i,
    input  logic [ADDR_W-1:0] nbase_i,
    input  logic [ADDR_W-1:0] dbase_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [2:0]        ie_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] ba_o,
    output logic              err_o
);

    exc_class_e        cls;
    exc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] vec;
    logic [IE_W-1:0]   ie_next;

    exc_classify u_classify (
        .cause_i (cause_i),
        .cls_o   (cls)
    );

    exc_vector_calc #(
        .ADDR_W    (ADDR_W),
        .CAUSE_W   (CAUSE_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_vector (
        .cause_i (cause_i),
        .remap_i (remap_i),
        .nbase_i (nbase_i),
        .dbase_i (dbase_i),
        .vec_o   (vec)
    );

    exc_ie_update u_ie (
        .ie_i  (ie_i),
        .cls_i (cls),
        .ie_o  (ie_next)
    );

    // Next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (req_i) begin
            unique case (cls)
                CLS_NORMAL: state_d = ST_NORMAL;
                CLS_DEBUG:  state_d = ST_DEBUG;
                default:    state_d = ST_FAULT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Architectural outputs, written on the transition into a taken state
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o <= '0;
            ie_o <= '0;
            ea_o <= '0;
            ba_o <= '0;
        end else begin
            unique case (state_d)
                ST_NORMAL: begin
                    pc_o <= vec;
                    ie_o <= ie_next;
                    ea_o <= pc_i;
                end
                ST_DEBUG: begin
                    pc_o <= vec;
                    ie_o <= ie_next;
                    ba_o <= pc_i;
                end
                default: ;
            endcase
        end
    end

    assign err_o = (state_q == ST_FAULT);

    // R6
    glb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cls != CLS_NONE) |=> !ie_o[IE_GLB]);

    // R9
    bad_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cls == CLS_NONE) |=> (err_o && $stable(pc_o) && $stable(ea_o) && $stable(ba_o) && $stable(ie_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!err_o && $stable(pc_o) && $stable(ie_o) && $stable(ea_o) && $stable(ba_o)));

    // R2
    ea_save_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cls == CLS_NORMAL) |=> (ea_o == $past(pc_i) && $stable(ba_o)));

    // R3
    ba_save_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cls == CLS_DEBUG) |=> (ba_o == $past(pc_i) && $stable(ea_o)));

    // R4
    sexc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cls == CLS_NORMAL && ie_i[IE_GLB]) |=> ie_o[IE_SEXC]);

    // R5
    sdbg_set_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && cls == CLS_DEBUG && ie_i[IE_GLB]) |=> ie_o[IE_SDBG]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && ie_o == '0 && ea_o == '0 && ba_o == '0 && !err_o));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [2:0]  cause_i;
    logic [31:0] pc_i;
    logic [2:0]  ie_i;
    logic        remap_i;
    logic [31:0] nbase_i;
    logic [31:0] dbase_i;
    logic [31:0] pc_o;
    logic [2:0]  ie_o;
    logic [31:0] ea_o;
    logic [31:0] ba_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_pc, m_ea, m_ba;
    logic [2:0]  m_ie;
    logic        m_err;

    always #5 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .cause_i (cause_i),
        .pc_i    (pc_i),
        .ie_i    (ie_i),
        .remap_i (remap_i),
        .nbase_i (nbase_i),
        .dbase_i (dbase_i),
        .pc_o    (pc_o),
        .ie_o    (ie_o),
        .ea_o    (ea_o),
        .ba_o    (ba_o),
        .err_o   (err_o)
    );

    function automatic bit is_dbg(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd3);
    endfunction

    function automatic bit is_norm(input logic [2:0] c);
        return (c == 3'd2) || (c >= 3'd4);
    endfunction

    function automatic logic [31:0] exp_vec(input logic rm, input logic [31:0] nb,
                                            input logic [31:0] db, input logic [2:0] c);
        return (rm ? db : nb) + 32'(c) * 32'd32;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step;
        m_err = 1'b0;
        if (rst) begin
            m_pc = '0; m_ie = '0; m_ea = '0; m_ba = '0;
        end else if (req_i) begin
            if (is_norm(cause_i)) begin
                m_pc = exp_vec(remap_i, nbase_i, dbase_i, cause_i);
                m_ea = pc_i;
                m_ie = {ie_i[2], ie_i[1] | ie_i[0], 1'b0};
            end else if (is_dbg(cause_i)) begin
                m_pc = exp_vec(remap_i, nbase_i, dbase_i, cause_i);
                m_ba = pc_i;
                m_ie = {ie_i[2] | ie_i[0], ie_i[1], 1'b0};
            end else begin
                m_err = 1'b1;
            end
        end
    endtask

    task automatic check_all(input string ctx);
        chk({ctx, " R7 R8 pc"}, pc_o, m_pc);
        chk({ctx, " R4 R5 R6 ie"}, 32'(ie_o), 32'(m_ie));
        chk({ctx, " R2 ea"}, ea_o, m_ea);
        chk({ctx, " R3 ba"}, ba_o, m_ba);
        chk({ctx, " R9 R10 err"}, 32'(err_o), 32'(m_err));
    endtask

    task automatic step(input string ctx, input logic r, input logic [2:0] c,
                        input logic [31:0] pc, input logic [2:0] ie, input logic rm,
                        input logic [31:0] nb, input logic [31:0] db);
        @(negedge clk);
        req_i = r; cause_i = c; pc_i = pc; ie_i = ie; remap_i = rm;
        nbase_i = nb; dbase_i = db;
        @(posedge clk);
        model_step();
        #1;
        check_all(ctx);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        rst = 1'b1; req_i = 1'b0; cause_i = '0; pc_i = '0; ie_i = '0;
        remap_i = 1'b0; nbase_i = '0; dbase_i = '0;
        m_pc = 'x; m_ie = 'x; m_ea = 'x; m_ba = 'x; m_err = 1'b0;
        // R1 reset values, with a pending request held off
        step("R1 reset", 1'b1, 3'd6, 32'h1234_5678, 3'b001, 1'b0, 32'h100, 32'h200);
        rst = 1'b0;
        // R2 R4 R6 R11 non-debug with global enable set
        step("R2 irq", 1'b1, 3'd6, 32'hAAAA_0004, 3'b001, 1'b0, 32'h1000, 32'h8000);
        // R10 hold after request
        step("R10 idle", 1'b0, 3'd2, 32'hDEAD_BEEF, 3'b111, 1'b1, 32'h0, 32'h0);
        // R3 R5 debug, global enable set
        step("R3 brk", 1'b1, 3'd1, 32'hBBBB_0010, 3'b001, 1'b0, 32'h1000, 32'h8000);
        // R8 remap with non-debug cause
        step("R8 remap norm", 1'b1, 3'd7, 32'h0000_0040, 3'b000, 1'b1, 32'h1000, 32'h8000);
        // R8 no remap with debug cause
        step("R8 no remap dbg", 1'b1, 3'd3, 32'h0000_0080, 3'b110, 1'b0, 32'h3000, 32'h9000);
        // R9 unhandled cause
        step("R9 reset cause", 1'b1, 3'd0, 32'hCCCC_0000, 3'b001, 1'b1, 32'h5000, 32'h6000);
        step("R10 after fault", 1'b0, 3'd0, 32'h0, 3'b000, 1'b0, 32'h0, 32'h0);
        // R7 wraparound of base + offset
        step("R7 wrap", 1'b1, 3'd7, 32'h0000_0100, 3'b000, 1'b0, 32'hFFFF_FFF0, 32'h0);
        // R4 saved bits never cleared with global enable low
        step("R4 keep", 1'b1, 3'd5, 32'h0000_0200, 3'b110, 1'b0, 32'h400, 32'h0);
        step("R5 keep", 1'b1, 3'd3, 32'h0000_0300, 3'b010, 1'b1, 32'h0, 32'h700);
        // R11 back-to-back requests
        for (int i = 2; i < 8; i++)
            step("R11 b2b", 1'b1, 3'(i), 32'h1000 + 32'(i), 3'b001, 1'(i & 1), 32'h2000, 32'h4000);
        for (int n = 0; n < 3000; n++) begin
            step("rand", 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), $urandom,
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), $urandom, $urandom);
        end
        // R1 reset again after activity
        rst = 1'b1;
        step("R1 rereset", 1'b0, 3'd0, 32'h0, 3'b000, 1'b0, 32'h0, 32'h0);
        rst = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule